// File: doc/BRIEF.md
# Write-Busy Status Read Responder

This block sits beside the storage array of a byte-wide nonvolatile memory model. It times the internal programming period and decides what a host read returns while that period runs. When the write path commits a cycle, it pulses a start strobe and presents the final byte written in that cycle. The responder captures the byte and raises a busy flag for a fixed number of clocks.

While busy is high, reads do not return array contents. They return a status word instead. The top bit is the inverse of the top bit of the captured byte. The next bit flips on every status read. The low bits echo the captured byte. A host can poll either of the two status bits to find out when programming has finished. Once the timer runs out, reads return the array data again, and no bit toggles any more.

A read request is answered one clock later with a valid pulse. The storage array and the page-load logic are outside this block.

Top module: `wbusy_resp`

## Requirements
- R1: A read request sampled while busy is low produces `rd_valid` high one clock later, with `rd_data` equal to `arr_data` as sampled at the request edge.
- R2: A start strobe sampled while busy is low raises `busy` from the next clock edge and captures `wr_byte` as the reference byte.
- R3: After an accepted start, `busy` stays high for exactly BUSY_CYCLES clock cycles and then drops.
- R4: A read request sampled while busy is high returns, on bit 7 of `rd_data`, the inverse of bit 7 of the reference byte.
- R5: A read request sampled while busy is high returns, on bits 5 down to 0, bits 5 down to 0 of the reference byte.
- R6: Bit 6 of successive status reads within one busy period alternates. It starts at 0 on the first status read after each accepted start, however many status reads the previous period had.
- R7: A status read is answered correctly in the very first cycle that busy is high.
- R8: A start strobe sampled while busy is high has no effect: the busy period is not extended and the reference byte is not replaced.
- R9: Once busy has dropped, reads return the full array data, with bit 6 taken from the array and not from the toggle.
- R10: While reset is held and just after it, `busy` and `rd_valid` are 0 and `rd_data` is all zeros.
- R11: A start strobe and a read request in the same idle cycle return array data for that read, and the busy period still begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_start | input | 1 | Strobe that commits a write cycle |
| wr_byte | input | DATA_W | Last byte written in the committed cycle |
| rd_req | input | 1 | Host read strobe |
| arr_data | input | DATA_W | Data read from the storage array |
| busy | output | 1 | Programming period in progress |
| rd_data | output | DATA_W | Read response: status word or array data |
| rd_valid | output | 1 | `rd_data` holds a response to the previous request |

## Verification
A reference model tracks the busy timer, the reference byte and the toggle. Each read's expected word is queued when the read is issued and compared when the response appears.

Idle reads are made against changing array values, which separates array passthrough from status substitution. Two reference bytes with opposite top bits show the inversion, and different low-bit patterns show the echo. Back-to-back status reads starting in the first busy cycle show the toggle. A period that ends after an odd number of status reads, followed by a fresh start, shows that the toggle is cleared at each start. A start issued during busy must leave both the timing and the status low bits unchanged. A start combined with a read in one idle cycle shows which state the read sees.

// File: rtl/wbr_pkg.sv
package wbr_pkg;

    // Status word shape for an 8-bit data path: poll bit, toggle bit, echo.
    typedef struct packed {
        logic       poll;
        logic       tog;
        logic [5:0] echo;
    } status8_t;

    // Source that feeds the read response register.
    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_ARRAY  = 2'd1,
        SRC_STATUS = 2'd2
    } rd_src_e;

    // Build a status word of any width from the reference byte and toggle.
    function automatic logic [63:0] build_status(
        input logic [63:0] ref_word,
        input logic        tog,
        input int          width
    );
        logic [63:0] w;
        w = ref_word;
        w[width-1] = ~ref_word[width-1];
        w[width-2] = tog;
        return w;
    endfunction

endpackage

// File: rtl/wbr_timer.sv
module wbr_timer #(
    parameter int BUSY_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start_req,
    output logic start_ok,
    output logic busy
);
    localparam int CNT_W = (BUSY_CYCLES < 2) ? 1 : $clog2(BUSY_CYCLES);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(BUSY_CYCLES - 1);

    logic [CNT_W-1:0] remain;

    // A start counts only while idle; a start during a busy period is dropped.
    assign start_ok = start_req && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (start_ok) begin
            busy   <= 1'b1;
            remain <= LOAD_VAL;
        end else if (busy) begin
            if (remain == '0) begin
                busy <= 1'b0;
            end else begin
                remain <= remain - 1'b1;
            end
        end
    end
endmodule

// File: rtl/wbr_status.sv
module wbr_status #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] wr_byte,
    input  logic              status_hit,
    output logic [DATA_W-1:0] status_word
);
    import wbr_pkg::*;

    logic [DATA_W-1:0] ref_q;
    logic              tog_q;
    logic [63:0]       built;

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q <= '0;
            tog_q <= 1'b0;
        end else if (load) begin
            ref_q <= wr_byte;
            tog_q <= 1'b0;
        end else if (status_hit) begin
            tog_q <= ~tog_q;
        end
    end

    assign built       = build_status(64'(ref_q), tog_q, DATA_W);
    assign status_word = built[DATA_W-1:0];
endmodule

// File: rtl/wbr_rdmux.sv
module wbr_rdmux #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_req,
    input  logic              busy,
    input  logic [DATA_W-1:0] arr_data,
    input  logic [DATA_W-1:0] status_word,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    import wbr_pkg::*;

    rd_src_e src;

    always_comb begin
        if (!rd_req)   src = SRC_NONE;
        else if (busy) src = SRC_STATUS;
        else           src = SRC_ARRAY;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= (src != SRC_NONE);
            case (src)
                SRC_STATUS: rd_data <= status_word;
                SRC_ARRAY:  rd_data <= arr_data;
                default:    rd_data <= rd_data;
            endcase
        end
    end
endmodule

// File: rtl/wbusy_resp.sv
module wbusy_resp #(
    parameter int DATA_W      = 8,
    parameter int BUSY_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_start,
    input  logic [DATA_W-1:0] wr_byte,
    input  logic              rd_req,
    input  logic [DATA_W-1:0] arr_data,
    output logic              busy,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    logic              start_ok;
    logic [DATA_W-1:0] status_word;

    wbr_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .start_req(wr_start),
        .start_ok (start_ok),
        .busy     (busy)
    );

    wbr_status #(.DATA_W(DATA_W)) u_status (
        .clk        (clk),
        .rst        (rst),
        .load       (start_ok),
        .wr_byte    (wr_byte),
        .status_hit (rd_req && busy),
        .status_word(status_word)
    );

    wbr_rdmux #(.DATA_W(DATA_W)) u_rdmux (
        .clk        (clk),
        .rst        (rst),
        .rd_req     (rd_req),
        .busy       (busy),
        .arr_data   (arr_data),
        .status_word(status_word),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid)
    );
endmodule

// File: rtl/wbusy_resp_chk.sv
module wbusy_resp_chk #(
    parameter int DATA_W      = 8,
    parameter int BUSY_CYCLES = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_start,
    input logic [DATA_W-1:0] wr_byte,
    input logic              rd_req,
    input logic [DATA_W-1:0] arr_data,
    input logic              busy,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_valid
);
    localparam int LEN_W = $clog2(BUSY_CYCLES + 2);

    logic [LEN_W-1:0]  len_q;
    logic [DATA_W-1:0] cap_q;
    logic              st_q;
    logic              seen_q;
    logic              prev_b6;

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q   <= '0;
            cap_q   <= '0;
            st_q    <= 1'b0;
            seen_q  <= 1'b0;
            prev_b6 <= 1'b0;
        end else begin
            len_q <= busy ? len_q + 1'b1 : '0;
            st_q  <= busy && rd_req;
            if (wr_start && !busy) begin
                cap_q  <= wr_byte;
                seen_q <= 1'b0;
            end else if (st_q) begin
                seen_q  <= 1'b1;
                prev_b6 <= rd_data[DATA_W-2];
            end
        end
    end

    assert_read_latency_R1: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> rd_valid);

    assert_idle_read_R1: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !busy) |=> (rd_data == $past(arr_data)));

    assert_rise_cause_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(wr_start));

    assert_idle_start_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_start && !busy) |=> busy);

    assert_busy_len_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (len_q == LEN_W'(BUSY_CYCLES)));

    assert_no_extend_R8: assert property (@(posedge clk) disable iff (rst)
        busy |-> (len_q < LEN_W'(BUSY_CYCLES)));

    assert_poll_bit_R4: assert property (@(posedge clk) disable iff (rst)
        st_q |-> (rd_data[DATA_W-1] == ~cap_q[DATA_W-1]));

    assert_echo_bits_R5: assert property (@(posedge clk) disable iff (rst)
        st_q |-> (rd_data[DATA_W-3:0] == cap_q[DATA_W-3:0]));

    assert_toggle_first_R6: assert property (@(posedge clk) disable iff (rst)
        (st_q && !seen_q) |-> (rd_data[DATA_W-2] == 1'b0));

    assert_toggle_flip_R6: assert property (@(posedge clk) disable iff (rst)
        (st_q && seen_q) |-> (rd_data[DATA_W-2] != prev_b6));
endmodule

bind wbusy_resp wbusy_resp_chk #(.DATA_W(DATA_W), .BUSY_CYCLES(BUSY_CYCLES)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_start(wr_start),
    .wr_byte (wr_byte),
    .rd_req  (rd_req),
    .arr_data(arr_data),
    .busy    (busy),
    .rd_data (rd_data),
    .rd_valid(rd_valid)
);

// File: tb/wbusy_resp_test.sv
module wbusy_resp_test;
    localparam int CLK_PERIOD = 10;
    localparam int DW         = 8;
    localparam int NBUSY      = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_start = 1'b0;
    logic [DW-1:0] wr_byte = '0;
    logic          rd_req = 1'b0;
    logic [DW-1:0] arr_data = '0;
    logic          busy;
    logic [DW-1:0] rd_data;
    logic          rd_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference model state, advanced at each rising edge.
    bit          m_busy = 0;
    int          m_cnt  = 0;
    logic [7:0]  m_ref  = '0;
    bit          m_tog  = 0;

    logic [DW-1:0] exp_q[$];
    string         tag_q[$];

    wbusy_resp #(.DATA_W(DW), .BUSY_CYCLES(NBUSY)) uut (
        .clk(clk), .rst(rst), .wr_start(wr_start), .wr_byte(wr_byte),
        .rd_req(rd_req), .arr_data(arr_data), .busy(busy),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_cnt = 0; m_ref = '0; m_tog = 0;
        end else if (wr_start && !m_busy) begin
            m_busy = 1; m_cnt = NBUSY; m_ref = wr_byte; m_tog = 0;
        end else if (m_busy) begin
            if (rd_req) m_tog = ~m_tog;
            m_cnt--;
            if (m_cnt == 0) m_busy = 0;
        end
    end

    // Monitor: busy against the model, read responses against the queue.
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R3 busy", {7'd0, busy}, {7'd0, m_busy});
            if (rd_valid) begin
                if (exp_q.size() == 0) begin
                    check("R1 unexpected response", rd_data, 'x);
                end else begin
                    string t;
                    logic [DW-1:0] e;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(t, rd_data, e);
                end
            end
        end
    end

    function automatic logic [DW-1:0] expect_now();
        if (m_busy) return {~m_ref[7], m_tog, m_ref[5:0]};
        return arr_data;
    endfunction

    task automatic do_read(string tag, logic [DW-1:0] arr);
        arr_data = arr;
        rd_req   = 1'b1;
        exp_q.push_back(expect_now());
        tag_q.push_back(tag);
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    task automatic do_start(logic [DW-1:0] b);
        wr_start = 1'b1;
        wr_byte  = b;
        @(negedge clk);
        wr_start = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_done();
        while (m_busy) @(negedge clk);
        idle(1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        idle(2);
        // R10: reset state while held
        check("R10 busy", {7'd0, busy}, 8'h00);
        check("R10 rd_valid", {7'd0, rd_valid}, 8'h00);
        check("R10 rd_data", rd_data, 8'h00);
        rst = 1'b0;
        idle(1);
        check("R10 after release", {6'd0, busy, rd_valid}, 8'h00);

        // R1: idle reads pass array data through
        do_read("R1 idle read", 8'h5A);
        do_read("R1 idle read", 8'hC0);
        idle(1);
        do_read("R1 idle read", 8'h3F);
        idle(2);

        // R2: start while idle, busy on next edge
        do_start(8'hA5);
        check("R2 busy after start", {7'd0, busy}, 8'h01);
        // R7: status read in the first busy cycle; R4 R5 R6 follow
        do_read("R7 first-cycle status", 8'hFF);
        do_read("R6 toggle", 8'h00);
        do_read("R4 poll bit", 8'hFF);
        do_read("R5 echo bits", 8'h00);
        idle(1);
        // R8: start during busy must not extend or replace the byte
        do_start(8'h3C);
        do_read("R8 ignored start", 8'h11);
        wait_done();

        // R9: after the period, array data returns unmodified
        do_read("R9 array after busy", 8'h40);
        do_read("R9 array after busy", 8'h40);
        do_read("R9 array after busy", 8'hBF);
        idle(2);

        // R6: odd number of status reads, then a fresh start clears toggle
        do_start(8'h7E);
        do_read("R4 poll bit clear", 8'h00);
        do_read("R6 toggle", 8'h00);
        do_read("R6 toggle", 8'h00);
        wait_done();
        do_start(8'hC3);
        idle(1);
        do_read("R6 cleared at start", 8'h00);
        do_read("R5 echo bits", 8'hFF);
        wait_done();

        // R11: start and read in the same idle cycle
        arr_data = 8'h96;
        wr_start = 1'b1;
        wr_byte  = 8'h0F;
        rd_req   = 1'b1;
        exp_q.push_back(8'h96);
        tag_q.push_back("R11 simultaneous start read");
        @(negedge clk);
        wr_start = 1'b0;
        rd_req   = 1'b0;
        check("R11 busy began", {7'd0, busy}, 8'h01);
        do_read("R11 status after", 8'h00);
        wait_done();
        idle(2);

        check("R1 queue drained", 8'(exp_q.size()), 8'h00);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule